// File: doc/BRIEF.md
# PLL Retuning Sequencer

This block retunes three clock-generation PLLs through their dynamic reconfiguration ports whenever a new pixel clock is requested. A requested frequency, in units of 10 kHz, comes in with a start pulse. The block sorts the value into a band and picks one of two stored 32-word configuration tables. One table runs the VCO at twenty times the pixel clock for slow pixel clocks. The other runs it at ten times the pixel clock for fast ones. Either way the VCO stays inside 400 MHz to 1000 MHz for pixel clocks from about 20 MHz to 100 MHz.

In a programming pass only the middle window of reconfiguration addresses is written. The lowest words are skipped because they carry placement-dependent bits. The topmost words are skipped because writing them upsets the PLL. The PLLs are handled strictly in series: the display output PLL first, then the two input sampler PLLs. Every transfer waits for the addressed PLL's ready handshake. A readback mode reads the full 32-word space of each PLL in the same order and streams the words out for inspection. A missing handshake aborts the pass after a configurable number of cycles.

Top module: `pll_retune_seq`

## Requirements
- R1: A programming start with `freq` below 2000 issues no port strobe, leaves `busy` low and pulses `err` for one cycle with `err_code` = 2'b01.
- R2: A programming start with `freq` of 10000 or more issues no port strobe, leaves `busy` low and pulses `err` for one cycle with `err_code` = 2'b10.
- R3: For `freq` from 2000 to 4499 the written data come from table `TABLE_20X`. For `freq` from 4500 to 9999 they come from `TABLE_10X`. The word written at address a is word a of the table, held at bits [16a+15:16a] of the parameter.
- R4: A programming pass writes addresses 6 to 26 in ascending order to each PLL. Addresses 0 to 5 and 27 to 31 are never written.
- R5: Each transfer is a one-cycle write or read strobe on one port, with address and write data valid in that cycle. The next strobe comes only after that port has raised its ready input.
- R6: PLL ports are serviced in the order 0, 1, 2, each one fully before the next. At most one strobe is high in any cycle, and only on the port being serviced.
- R7: A start with `dump_mode` high ignores `freq` and reads addresses 0 to 31 of ports 0, 1, 2 in that order. On each ready it gives a one-cycle `dump_valid` with the read word, the port index and the address.
- R8: `busy` rises in the cycle after an accepted start. It falls in the same cycle as a one-cycle `done` pulse, one cycle after the ready of the final transfer.
- R9: A start pulse that arrives while `busy` is high has no effect on the running pass, on `err` or on `done`.
- R10: If ready does not arrive within `TIMEOUT` cycles of a strobe, `err` pulses with `err_code` = 2'b11 exactly `TIMEOUT` cycles after the strobe cycle. `busy` falls at the same time, `done` stays low and no further strobe is issued.
- R11: While `rst` is high, `busy`, `done`, `err`, `dump_valid` and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, one cycle |
| dump_mode | input | 1 | Readback instead of programming, sampled with start |
| freq | input | FREQ_W | Requested pixel clock in 10 kHz units |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse at the end of a completed pass |
| err | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 01 too low, 10 too high, 11 handshake timeout |
| dump_valid | output | 1 | Readback word valid |
| dump_pll | output | PSEL_W | Port index of the readback word |
| dump_addr | output | ADDR_W | Address of the readback word |
| dump_data | output | DATA_W | Readback word |
| drp_addr | output | N_PLL x ADDR_W | Per-port address |
| drp_di | output | N_PLL x DATA_W | Per-port write data |
| drp_we | output | N_PLL | Per-port write strobe |
| drp_re | output | N_PLL | Per-port read strobe |
| drp_do | input | N_PLL x DATA_W | Per-port read data |
| drp_rdy | input | N_PLL | Per-port ready |

## Verification
The bench targets the band edges 1999, 2000, 4499, 4500, 9999 and 10000. An off-by-one compare there would either reject a legal clock or write the other multiplier's table, and the per-strobe data check sees that at once. It runs readbacks after programming passes to show that the low and top words kept their preset values. A window bound that is one too wide would overwrite them, and a readback that starts or stops wrong loses words from the stream. Further passes use uneven ready latencies per port, a second start issued while a pass is running, and a port that never answers. These expose a sequencer that moves on before ready, restarts on a stray start, or gets the timeout length wrong by a cycle.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    BAND_LOW,
    BAND_20X,
    BAND_10X,
    BAND_HIGH
  } band_t;

  localparam logic [1:0] ERR_NONE    = 2'b00;
  localparam logic [1:0] ERR_LOW     = 2'b01;
  localparam logic [1:0] ERR_HIGH    = 2'b10;
  localparam logic [1:0] ERR_TIMEOUT = 2'b11;

  localparam int DEF_WORDS = 32;
  localparam int DEF_DW    = 16;

  // placeholder table image; real contents are given per instance
  function automatic logic [DEF_WORDS*DEF_DW-1:0] fill_table(input logic [7:0] seed);
    logic [DEF_WORDS*DEF_DW-1:0] r;
    r = '0;
    for (int k = 0; k < DEF_WORDS; k++) begin
      r[k*DEF_DW +: DEF_DW] = {seed + 8'(k), 8'(k * 13)};
    end
    return r;
  endfunction

endpackage

// File: rtl/pll_band_sel.sv
module pll_band_sel
  import pll_retune_pkg::*;
#(
  parameter int FREQ_W      = 14,
  parameter int LOW_LIMIT   = 2000,
  parameter int SPLIT_LIMIT = 4500,
  parameter int HIGH_LIMIT  = 10000
) (
  input  logic [FREQ_W-1:0] freq,
  output band_t             band
);

  localparam int CMP_W = FREQ_W + 1;

  logic [CMP_W-1:0] f_ext;

  always_comb begin
    f_ext = {1'b0, freq};
    if (f_ext < CMP_W'(LOW_LIMIT))
      band = BAND_LOW;
    else if (f_ext < CMP_W'(SPLIT_LIMIT))
      band = BAND_20X;
    else if (f_ext < CMP_W'(HIGH_LIMIT))
      band = BAND_10X;
    else
      band = BAND_HIGH;
  end

endmodule

// File: rtl/pll_cfg_rom.sv
module pll_cfg_rom #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] TABLE_A = '0,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] TABLE_B = '0
) (
  input  logic              clk,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] q
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int DEPTH = 2 * WORDS;
  localparam logic [DEPTH*DATA_W-1:0] IMAGE = {TABLE_B, TABLE_A};

  logic [DATA_W-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i] = IMAGE[i*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    q <= rom[{sel, addr}];
  end

endmodule

// File: rtl/pll_drp_port_mux.sv
module pll_drp_port_mux #(
  parameter int N_PLL  = 3,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int PSEL_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          fire_wr,
  input  logic                          fire_rd,
  input  logic [PSEL_W-1:0]             pll_sel,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [N_PLL-1:0]              drp_rdy,
  input  logic [N_PLL-1:0][DATA_W-1:0]  drp_do,
  output logic [N_PLL-1:0]              drp_we,
  output logic [N_PLL-1:0]              drp_re,
  output logic [N_PLL-1:0][ADDR_W-1:0]  drp_addr,
  output logic [N_PLL-1:0][DATA_W-1:0]  drp_di,
  output logic                          rdy_sel,
  output logic [DATA_W-1:0]             do_sel
);

  logic [N_PLL-1:0] hit;

  for (genvar g = 0; g < N_PLL; g++) begin : g_hit
    assign hit[g] = (pll_sel == PSEL_W'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drp_we   <= '0;
      drp_re   <= '0;
      drp_addr <= '0;
      drp_di   <= '0;
    end else begin
      for (int i = 0; i < N_PLL; i++) begin
        drp_we[i] <= fire_wr && hit[i];
        drp_re[i] <= fire_rd && hit[i];
        if ((fire_wr || fire_rd) && hit[i])
          drp_addr[i] <= addr;
        if (fire_wr && hit[i])
          drp_di[i] <= wdata;
      end
    end
  end

  always_comb begin
    rdy_sel = 1'b0;
    do_sel  = '0;
    for (int i = 0; i < N_PLL; i++) begin
      if (hit[i]) begin
        rdy_sel = drp_rdy[i];
        do_sel  = drp_do[i];
      end
    end
  end

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_retune_pkg::*;
#(
  parameter int N_PLL       = 3,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int FREQ_W      = 14,
  parameter int WR_FIRST    = 6,
  parameter int WR_LAST     = 26,
  parameter int TIMEOUT     = 64,
  parameter int LOW_LIMIT   = 2000,
  parameter int SPLIT_LIMIT = 4500,
  parameter int HIGH_LIMIT  = 10000,
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] TABLE_20X = fill_table(8'h2A),
  parameter logic [(1<<ADDR_W)*DATA_W-1:0] TABLE_10X = fill_table(8'h5C),
  localparam int PSEL_W = (N_PLL > 1) ? $clog2(N_PLL) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          dump_mode,
  input  logic [FREQ_W-1:0]             freq,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic [1:0]                    err_code,
  output logic                          dump_valid,
  output logic [PSEL_W-1:0]             dump_pll,
  output logic [ADDR_W-1:0]             dump_addr,
  output logic [DATA_W-1:0]             dump_data,
  output logic [N_PLL-1:0][ADDR_W-1:0]  drp_addr,
  output logic [N_PLL-1:0][DATA_W-1:0]  drp_di,
  output logic [N_PLL-1:0]              drp_we,
  output logic [N_PLL-1:0]              drp_re,
  input  logic [N_PLL-1:0][DATA_W-1:0]  drp_do,
  input  logic [N_PLL-1:0]              drp_rdy
);

  localparam int WORDS = 1 << ADDR_W;
  localparam int TMR_W = $clog2(TIMEOUT + 1);

  seq_state_t        state;
  band_t             band;
  logic              tsel;
  logic              is_dump;
  logic [PSEL_W-1:0] pll_idx;
  logic [ADDR_W-1:0] word_addr;
  logic [TMR_W-1:0]  timer;
  logic [ADDR_W-1:0] first_addr;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] rom_q;
  logic              fire_wr;
  logic              fire_rd;
  logic              rdy_sel;
  logic [DATA_W-1:0] do_sel;

  pll_band_sel #(
    .FREQ_W      (FREQ_W),
    .LOW_LIMIT   (LOW_LIMIT),
    .SPLIT_LIMIT (SPLIT_LIMIT),
    .HIGH_LIMIT  (HIGH_LIMIT)
  ) u_band (
    .freq (freq),
    .band (band)
  );

  pll_cfg_rom #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .TABLE_A (TABLE_20X),
    .TABLE_B (TABLE_10X)
  ) u_rom (
    .clk  (clk),
    .sel  (tsel),
    .addr (word_addr),
    .q    (rom_q)
  );

  pll_drp_port_mux #(
    .N_PLL  (N_PLL),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PSEL_W (PSEL_W)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .fire_wr  (fire_wr),
    .fire_rd  (fire_rd),
    .pll_sel  (pll_idx),
    .addr     (word_addr),
    .wdata    (rom_q),
    .drp_rdy  (drp_rdy),
    .drp_do   (drp_do),
    .drp_we   (drp_we),
    .drp_re   (drp_re),
    .drp_addr (drp_addr),
    .drp_di   (drp_di),
    .rdy_sel  (rdy_sel),
    .do_sel   (do_sel)
  );

  always_comb begin
    first_addr = is_dump ? '0 : ADDR_W'(WR_FIRST);
    last_addr  = is_dump ? ADDR_W'(WORDS - 1) : ADDR_W'(WR_LAST);
    fire_wr    = (state == ST_ISSUE) && !is_dump;
    fire_rd    = (state == ST_ISSUE) && is_dump;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      err_code   <= ERR_NONE;
      tsel       <= 1'b0;
      is_dump    <= 1'b0;
      pll_idx    <= '0;
      word_addr  <= '0;
      timer      <= '0;
      dump_valid <= 1'b0;
      dump_pll   <= '0;
      dump_addr  <= '0;
      dump_data  <= '0;
    end else begin
      done       <= 1'b0;
      err        <= 1'b0;
      dump_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (dump_mode) begin
              is_dump   <= 1'b1;
              pll_idx   <= '0;
              word_addr <= '0;
              busy      <= 1'b1;
              state     <= ST_FETCH;
            end else if (band == BAND_LOW) begin
              err      <= 1'b1;
              err_code <= ERR_LOW;
            end else if (band == BAND_HIGH) begin
              err      <= 1'b1;
              err_code <= ERR_HIGH;
            end else begin
              is_dump   <= 1'b0;
              tsel      <= (band == BAND_10X);
              pll_idx   <= '0;
              word_addr <= ADDR_W'(WR_FIRST);
              busy      <= 1'b1;
              state     <= ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          state <= ST_ISSUE;
        end
        ST_ISSUE: begin
          timer <= '0;
          state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rdy_sel) begin
            if (is_dump) begin
              dump_valid <= 1'b1;
              dump_pll   <= pll_idx;
              dump_addr  <= word_addr;
              dump_data  <= do_sel;
            end
            if (word_addr == last_addr) begin
              if (pll_idx == PSEL_W'(N_PLL - 1)) begin
                done  <= 1'b1;
                busy  <= 1'b0;
                state <= ST_IDLE;
              end else begin
                pll_idx   <= pll_idx + 1'b1;
                word_addr <= first_addr;
                state     <= ST_FETCH;
              end
            end else begin
              word_addr <= word_addr + 1'b1;
              state     <= ST_FETCH;
            end
          end else if (timer == TMR_W'(TIMEOUT - 1)) begin
            err      <= 1'b1;
            err_code <= ERR_TIMEOUT;
            busy     <= 1'b0;
            state    <= ST_IDLE;
          end else begin
            timer <= timer + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pll_retune_chk.sv
module pll_retune_chk #(
  parameter int N_PLL    = 3,
  parameter int ADDR_W   = 5,
  parameter int WR_FIRST = 6,
  parameter int WR_LAST  = 26
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         busy,
  input logic                         done,
  input logic                         err,
  input logic [1:0]                   err_code,
  input logic                         dump_valid,
  input logic [N_PLL-1:0]             drp_we,
  input logic [N_PLL-1:0]             drp_re,
  input logic [N_PLL-1:0][ADDR_W-1:0] drp_addr
);

  logic any_strobe;
  assign any_strobe = |(drp_we | drp_re);

  // R6
  one_port_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({drp_we, drp_re}) <= 1);

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    any_strobe |=> !any_strobe);

  // R8
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
    any_strobe |-> busy);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R7
  dump_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dump_valid |=> !dump_valid);

  // R1
  range_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err && err_code != 2'b11) |-> (!$past(busy) && !busy && err_code != 2'b00));

  // R10
  timeout_err_chk: assert property (@(posedge clk) disable iff (rst)
    (err && err_code == 2'b11) |-> ($past(busy) && !busy && !done));

  for (genvar g = 0; g < N_PLL; g++) begin : g_win
    // R4
    wr_window_chk: assert property (@(posedge clk) disable iff (rst)
      drp_we[g] |-> (drp_addr[g] >= ADDR_W'(WR_FIRST) && drp_addr[g] <= ADDR_W'(WR_LAST)));
  end

endmodule

bind pll_retune_seq pll_retune_chk #(
  .N_PLL    (N_PLL),
  .ADDR_W   (ADDR_W),
  .WR_FIRST (WR_FIRST),
  .WR_LAST  (WR_LAST)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .done       (done),
  .err        (err),
  .err_code   (err_code),
  .dump_valid (dump_valid),
  .drp_we     (drp_we),
  .drp_re     (drp_re),
  .drp_addr   (drp_addr)
);

// File: tb/test_pll_retune_seq.sv
module test_pll_retune_seq;

  localparam int NP = 3;
  localparam int AW = 5;
  localparam int DW = 16;
  localparam int FW = 14;
  localparam int TO = 20;
  localparam logic [7:0] SEED_A = 8'hC3;
  localparam logic [7:0] SEED_B = 8'h3C;

  function automatic logic [DW-1:0] tbl_word(input logic [7:0] seed, input int k);
    return {seed ^ 8'(k), 8'(k * 29 + 5)};
  endfunction

  function automatic logic [32*DW-1:0] mk_tbl(input logic [7:0] seed);
    logic [32*DW-1:0] r;
    for (int k = 0; k < 32; k++) r[k*DW +: DW] = tbl_word(seed, k);
    return r;
  endfunction

  typedef struct {
    int          pll;
    int          addr;
    bit          wr;
    logic [15:0] data;
  } txn_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic dump_mode = 1'b0;
  logic [FW-1:0] freq = '0;
  logic busy, done, err, dump_valid;
  logic [1:0] err_code;
  logic [1:0] dump_pll;
  logic [AW-1:0] dump_addr;
  logic [DW-1:0] dump_data;
  logic [NP-1:0][AW-1:0] drp_addr;
  logic [NP-1:0][DW-1:0] drp_di;
  logic [NP-1:0] drp_we, drp_re;
  logic [NP-1:0][DW-1:0] drp_do = '0;
  logic [NP-1:0] drp_rdy = '0;

  always #2 clk = ~clk;

  pll_retune_seq #(
    .N_PLL     (NP),
    .ADDR_W    (AW),
    .DATA_W    (DW),
    .FREQ_W    (FW),
    .TIMEOUT   (TO),
    .TABLE_20X (mk_tbl(SEED_A)),
    .TABLE_10X (mk_tbl(SEED_B))
  ) i_pll_retune_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .dump_mode  (dump_mode),
    .freq       (freq),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .err_code   (err_code),
    .dump_valid (dump_valid),
    .dump_pll   (dump_pll),
    .dump_addr  (dump_addr),
    .dump_data  (dump_data),
    .drp_addr   (drp_addr),
    .drp_di     (drp_di),
    .drp_we     (drp_we),
    .drp_re     (drp_re),
    .drp_do     (drp_do),
    .drp_rdy    (drp_rdy)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int last_code = 0;
  int err_cyc = 0;
  int strobe_cyc = 0;
  int lat [NP];
  bit dead [NP];
  int pcnt [NP];
  int paddr [NP];
  logic [DW-1:0] dev_mem [NP][32];
  logic [DW-1:0] model_mem [NP][32];
  txn_t exp_q [$];
  txn_t dump_q [$];

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // PLL port responders
  initial begin
    for (int p = 0; p < NP; p++) begin
      lat[p] = 1; dead[p] = 0; pcnt[p] = 0; paddr[p] = 0;
      for (int a = 0; a < 32; a++) begin
        dev_mem[p][a]   = 16'(16'h1000 * (p + 1) + a);
        model_mem[p][a] = 16'(16'h1000 * (p + 1) + a);
      end
    end
    forever begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        drp_rdy[p] = 1'b0;
        if (pcnt[p] > 0) begin
          pcnt[p]--;
          if (pcnt[p] == 0) begin
            drp_rdy[p] = 1'b1;
            drp_do[p]  = dev_mem[p][paddr[p]];
          end
        end
        if ((drp_we[p] || drp_re[p]) && !dead[p]) begin
          paddr[p] = int'(drp_addr[p]);
          if (drp_we[p]) dev_mem[p][paddr[p]] = drp_di[p];
          pcnt[p] = lat[p];
        end
      end
    end
  end

  // reference comparison on every clock
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        int ns;
        int sp;
        ns = $countones({drp_we, drp_re});
        if (ns > 1) chk(0, "R6 multiple strobes", ns, 1);
        if (ns == 1) begin
          sp = 0;
          for (int p = 0; p < NP; p++) if (drp_we[p] || drp_re[p]) sp = p;
          strobe_cyc = cyc;
          chk(busy, "R8 strobe while idle", int'(busy), 1);
          if (exp_q.size() == 0) begin
            chk(0, "R4 unexpected strobe addr", int'(drp_addr[sp]), -1);
          end else begin
            txn_t t;
            t = exp_q.pop_front();
            chk(sp == t.pll, "R6 port order", sp, t.pll);
            chk(int'(drp_addr[sp]) == t.addr, "R4 strobe address", int'(drp_addr[sp]), t.addr);
            chk(drp_we[sp] == t.wr, "R5 strobe kind", int'(drp_we[sp]), int'(t.wr));
            if (t.wr) chk(drp_di[sp] == t.data, "R3 write data", int'(drp_di[sp]), int'(t.data));
          end
        end
        if (dump_valid) begin
          if (dump_q.size() == 0) begin
            chk(0, "R7 unexpected dump word", int'(dump_addr), -1);
          end else begin
            txn_t d;
            d = dump_q.pop_front();
            chk(int'(dump_pll) == d.pll, "R7 dump port", int'(dump_pll), d.pll);
            chk(int'(dump_addr) == d.addr, "R7 dump address", int'(dump_addr), d.addr);
            chk(dump_data == d.data, "R7 dump data", int'(dump_data), int'(d.data));
          end
        end
        if (done) done_cnt++;
        if (err) begin
          err_cnt++;
          last_code = int'(err_code);
          err_cyc = cyc;
        end
      end
      cyc++;
      if (cyc >= 150000) begin
        chk(0, "watchdog", cyc, 150000);
        summary();
      end
    end
  end

  task automatic pulse_start(input int f, input bit dm);
    @(negedge clk);
    freq = FW'(f);
    dump_mode = dm;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dump_mode = 1'b0;
  endtask

  task automatic wait_end(input int d0, input int e0);
    int n;
    n = 0;
    while (done_cnt == d0 && err_cnt == e0 && n < 8000) begin
      @(posedge clk);
      n++;
    end
    chk(n < 8000, "R8 pass completes", n, 0);
    @(negedge clk);
  endtask

  task automatic queue_writes(input int p, input bit sel);
    for (int a = 6; a <= 26; a++) begin
      txn_t t;
      t.pll = p; t.addr = a; t.wr = 1'b1;
      t.data = sel ? tbl_word(SEED_B, a) : tbl_word(SEED_A, a);
      exp_q.push_back(t);
      model_mem[p][a] = t.data;
    end
  endtask

  task automatic run_reject(input int f, input int code, input string req);
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    pulse_start(f, 1'b0);
    chk(!busy, req, int'(busy), 0);
    repeat (3) @(negedge clk);
    chk(err_cnt == e0 + 1, req, err_cnt - e0, 1);
    chk(last_code == code, req, last_code, code);
    chk(done_cnt == d0, req, done_cnt - d0, 0);
  endtask

  task automatic run_prog(input int f, input bit sel, input string req);
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    for (int p = 0; p < NP; p++) queue_writes(p, sel);
    pulse_start(f, 1'b0);
    chk(busy, "R8 busy after start", int'(busy), 1);
    wait_end(d0, e0);
    chk(done_cnt == d0 + 1, "R8 done pulse", done_cnt - d0, 1);
    chk(err_cnt == e0, req, err_cnt - e0, 0);
    chk(exp_q.size() == 0, "R4 all writes issued", exp_q.size(), 0);
    chk(!busy, "R8 busy cleared", int'(busy), 0);
  endtask

  task automatic run_dump(input int f);
    int d0, e0;
    d0 = done_cnt; e0 = err_cnt;
    for (int p = 0; p < NP; p++) begin
      for (int a = 0; a < 32; a++) begin
        txn_t t;
        t.pll = p; t.addr = a; t.wr = 1'b0; t.data = model_mem[p][a];
        exp_q.push_back(t);
        dump_q.push_back(t);
      end
    end
    pulse_start(f, 1'b1);
    wait_end(d0, e0);
    chk(done_cnt == d0 + 1, "R7 dump done", done_cnt - d0, 1);
    chk(dump_q.size() == 0, "R7 all words dumped", dump_q.size(), 0);
    chk(exp_q.size() == 0, "R7 all reads issued", exp_q.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R11
    chk(!busy && !done && !err, "R11 reset outputs", int'({busy, done, err}), 0);
    chk(drp_we == '0 && drp_re == '0 && !dump_valid, "R11 reset strobes",
        int'({drp_we, drp_re, dump_valid}), 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    run_reject(1999, 1, "R1 below band");
    run_reject(0, 1, "R1 zero");
    run_reject(10000, 2, "R2 above band");
    run_reject(16383, 2, "R2 maximum");

    run_prog(2000, 1'b0, "R3 low edge 20x");
    lat[0] = 2; lat[1] = 1; lat[2] = 3;
    run_prog(4499, 1'b0, "R3 top of 20x band");
    run_prog(4500, 1'b1, "R3 bottom of 10x band");
    lat[0] = 1; lat[1] = 1; lat[2] = 1;
    run_prog(9999, 1'b1, "R3 top of 10x band");

    // R7: freq value is irrelevant in readback
    run_dump(0);

    // R9: stray start while busy
    begin
      int d0, e0;
      d0 = done_cnt; e0 = err_cnt;
      lat[1] = 2;
      for (int p = 0; p < NP; p++) queue_writes(p, 1'b0);
      pulse_start(3000, 1'b0);
      repeat (10) @(negedge clk);
      pulse_start(50, 1'b1);
      pulse_start(12000, 1'b0);
      wait_end(d0, e0);
      chk(done_cnt == d0 + 1, "R9 single done", done_cnt - d0, 1);
      chk(err_cnt == e0, "R9 no error from ignored start", err_cnt - e0, 0);
      chk(exp_q.size() == 0, "R9 pass unchanged", exp_q.size(), 0);
      lat[1] = 1;
    end

    // R10: port 1 never answers
    begin
      int d0, e0;
      txn_t t;
      d0 = done_cnt; e0 = err_cnt;
      dead[1] = 1'b1;
      queue_writes(0, 1'b1);
      t.pll = 1; t.addr = 6; t.wr = 1'b1; t.data = tbl_word(SEED_B, 6);
      exp_q.push_back(t);
      pulse_start(7000, 1'b0);
      wait_end(d0, e0);
      chk(err_cnt == e0 + 1, "R10 timeout error", err_cnt - e0, 1);
      chk(last_code == 3, "R10 timeout code", last_code, 3);
      chk(err_cyc - strobe_cyc == TO, "R10 timeout length", err_cyc - strobe_cyc, TO);
      chk(done_cnt == d0, "R10 no done", done_cnt - d0, 0);
      chk(!busy, "R10 busy cleared", int'(busy), 0);
      repeat (30) @(negedge clk);
      chk(exp_q.size() == 0, "R10 no further strobes", exp_q.size(), 0);
      dead[1] = 1'b0;
    end

    // R4: skipped words kept their preset values
    run_dump(9000);

    summary();
  end

endmodule